// File: doc/BRIEF.md
# SD Card Single-Block Transfer Engine

This engine moves one fixed-size block (512 bytes by default) between a local byte buffer and a memory card that is driven in SPI mode. A transfer starts with a one-cycle `start` pulse carrying a byte address, a direction select and a flag that says whether the card addresses by block (high capacity) or by byte. The engine then asks an external command engine to issue the single-block read or write command. After that it drives an external byte-exchange port to run the data phase: the start token, the payload, the check bytes, the card's data-response token and the busy wait.

The command engine and the SPI shifter sit outside this block. The engine only sequences bytes through them. Each wait loop (for the read start token and for the end of the card's busy period) stops after a number of exchanged bytes set at an input port. When the transfer finishes, `done` pulses and a three-bit status code says how it ended. That code is held until the next start.

Top module: `sd_block_xfer`

## Requirements
- R1: An address whose low 9 bits are not all zero is refused. `done` pulses in the cycle after `start`, status becomes 7, and no command or byte exchange takes place.
- R2: The command index is 17 for a read (`wr`=0) and 24 for a write (`wr`=1). The argument is the address shifted right by 9 when `hc`=1 and the unchanged byte address when `hc`=0. `cmd_req` stays high until `cmd_ack`.
- R3: A command response `cmd_r1` other than 0x00 ends the transfer. `done` pulses in the next cycle with status 1, and no byte exchange takes place.
- R4: On a read, every received byte before 0xFE is discarded. The 512 bytes that follow the token are written to buffer addresses 0 to 511 in the order they arrive, even if some of them are 0xFE.
- R5: On a read, the two check bytes after the payload are exchanged and dropped. The transfer then ends with status 0, so a read with P leading idle bytes uses P+515 exchanges.
- R6: If `token_limit` exchanged bytes pass without 0xFE, the read ends with status 2 after exactly `token_limit` exchanges.
- R7: On a write, the bytes sent are 0xFE, then buffer bytes 0 to 511 in order, then 0xFF and 0xFF.
- R8: The byte after the write's two check bytes is the data response. Its bits 3:1 give the status: 010 gives 0, 101 gives 3, 110 gives 4, and any other value gives 5.
- R9: After the data response the engine keeps exchanging bytes until it receives 0xFF, and only then pulses `done`. This also happens when the response was a rejection.
- R10: If `busy_limit` bytes pass in the busy wait without 0xFF, the write ends with status 6. This replaces any earlier code.
- R11: `done` is a single-cycle pulse. `err` is high exactly when status is non-zero, and status holds its value until the next accepted start. After reset, `done`, `err` and status are 0.
- R12: `cmd_req` and `xb_req` are never high together. `xb_tx` stays stable while a byte request is pending. Every byte sent outside the write token, payload and check bytes is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a transfer (sampled while idle) |
| wr | input | 1 | 1 = write block to card, 0 = read block |
| hc | input | 1 | Card addresses by block number |
| addr | input | 32 | Byte address of the block |
| token_limit | input | 16 | Maximum bytes examined while waiting for the read token |
| busy_limit | input | 16 | Maximum bytes examined while the card is busy |
| cmd_req | output | 1 | Request to the command engine, held until acknowledge |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_ack | input | 1 | Command engine finished (one-cycle pulse) |
| cmd_r1 | input | 8 | First response byte, valid with `cmd_ack` |
| xb_req | output | 1 | Request one SPI byte exchange |
| xb_tx | output | 8 | Byte to send |
| xb_done | input | 1 | Exchange finished (one-cycle pulse) |
| xb_rx | input | 8 | Byte received, valid with `xb_done` |
| buf_addr | output | 9 | Buffer byte address |
| buf_we | output | 1 | Buffer write strobe (read direction) |
| buf_wdata | output | 8 | Buffer write data |
| buf_rdata | input | 8 | Buffer read data for `buf_addr`, same cycle |
| done | output | 1 | Transfer finished (one-cycle pulse) |
| err | output | 1 | Last transfer ended with a non-zero status |
| status | output | 3 | Completion code, see R1 to R10 |

## Verification
Some rules hold on every cycle and are checked by assertions:
- the two request lines never overlap;
- the command request and the byte to send stay stable while their handshakes are pending;
- buffer writes happen only on a completed exchange;
- `done` lasts a single cycle;
- a misaligned start and a rejected command each finish in the following cycle with their own codes.

Other behaviour can only be shown by whole transfers driven by the bench's card model:
- the command argument for each card type;
- in-order storage of exactly 512 bytes after the token;
- the exact exchange counts, including the dropped check bytes;
- the full write byte stream;
- each data-response decoding;
- the two timeouts, and the busy wait that still runs after a rejection.

// File: rtl/sd_xfer_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the single-block transfer engine.
// Assumes the SPI-mode command indices and token values of the card protocol.
package sd_xfer_pkg;

    typedef enum logic [3:0] {
        XS_IDLE, XS_CMD, XS_TOKEN, XS_RDATA, XS_RCRC,
        XS_WTOK, XS_WDATA, XS_WCRC, XS_DRESP, XS_BUSY, XS_FIN
    } xfer_state_t;

    typedef enum logic [2:0] {
        ST_OK     = 3'd0,
        ST_R1     = 3'd1,
        ST_TOKTO  = 3'd2,
        ST_DCRC   = 3'd3,
        ST_DWERR  = 3'd4,
        ST_DBAD   = 3'd5,
        ST_BUSYTO = 3'd6,
        ST_ALIGN  = 3'd7
    } xfer_status_t;

    localparam logic [5:0] CMD_RD_BLOCK = 6'd17;
    localparam logic [5:0] CMD_WR_BLOCK = 6'd24;
    localparam logic [7:0] TOKEN_START  = 8'hFE;
    localparam logic [7:0] FILL_BYTE    = 8'hFF;
    localparam logic [2:0] DR_ACCEPT    = 3'b010;
    localparam logic [2:0] DR_CRC       = 3'b101;
    localparam logic [2:0] DR_WRITE     = 3'b110;

endpackage

// File: rtl/sd_xfer_arg.sv
`timescale 1ns/1ps
// Command argument builder: passes the byte address through, or turns it into
// a block number for block-addressed cards. Also flags block alignment.
// Assumes the block size is 2**SHIFT bytes.
module sd_xfer_arg #(
    parameter int ADDR_W = 32,
    parameter int SHIFT  = 9
) (
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic              hc,
    output logic [31:0]       arg,
    output logic              aligned
);
    logic [ADDR_W-1:0] blk_num;

    // Pick block number or byte address, and test the offset bits.
    always_comb begin
        blk_num = byte_addr >> SHIFT;
        arg     = hc ? 32'(blk_num) : 32'(byte_addr);
        aligned = (byte_addr[SHIFT-1:0] == '0);
    end
endmodule

// File: rtl/sd_xfer_wait.sv
`timescale 1ns/1ps
// Byte-count limiter for polling loops. It counts the bytes examined since
// clr and raises last when the byte now being examined is the final one
// allowed. A limit of zero behaves as a limit of one.
module sd_xfer_wait #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt;

    // Count examined bytes; restart whenever the loop is (re)entered.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (step) cnt <= cnt + 1'b1;
    end

    // Current byte is the limit-th one.
    assign last = (({1'b0, cnt} + (W+1)'(1)) >= {1'b0, limit});
endmodule

// File: rtl/sd_block_xfer.sv
`timescale 1ns/1ps
// Single-block transfer engine. It issues the block read or write command
// through an external command engine, then runs the data phase byte by byte
// through an external SPI exchange port. For a read: token search, payload,
// two dropped check bytes. For a write: token, payload, dummy check bytes,
// data-response decode and busy poll.
// Assumes BLK_BYTES is a power of two, the buffer read is combinational, and
// each request is held until its one-cycle done/ack pulse.
module sd_block_xfer
    import sd_xfer_pkg::*;
#(
    parameter int BLK_BYTES = 512,
    parameter int ADDR_W    = 32,
    parameter int TO_W      = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         wr,
    input  logic                         hc,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [TO_W-1:0]              token_limit,
    input  logic [TO_W-1:0]              busy_limit,
    output logic                         cmd_req,
    output logic [5:0]                   cmd_idx,
    output logic [31:0]                  cmd_arg,
    input  logic                         cmd_ack,
    input  logic [7:0]                   cmd_r1,
    output logic                         xb_req,
    output logic [7:0]                   xb_tx,
    input  logic                         xb_done,
    input  logic [7:0]                   xb_rx,
    output logic [$clog2(BLK_BYTES)-1:0] buf_addr,
    output logic                         buf_we,
    output logic [7:0]                   buf_wdata,
    input  logic [7:0]                   buf_rdata,
    output logic                         done,
    output logic                         err,
    output logic [2:0]                   status
);
    localparam int             IW       = $clog2(BLK_BYTES);
    localparam logic [IW-1:0]  LAST_IDX = IW'(BLK_BYTES - 1);
    localparam logic [IW-1:0]  CRC_LAST = IW'(1);

    xfer_state_t  st;
    xfer_status_t status_q;
    logic [IW-1:0] idx;
    logic          wr_q;
    logic [5:0]    cmd_idx_q;
    logic [31:0]   cmd_arg_q;
    logic [31:0]   arg_w;
    logic          aligned_w;
    logic          wait_clr, wait_step, wait_last;
    logic [TO_W-1:0] wait_lim;

    sd_xfer_arg #(.ADDR_W(ADDR_W), .SHIFT(IW)) u_arg (
        .byte_addr (addr),
        .hc        (hc),
        .arg       (arg_w),
        .aligned   (aligned_w)
    );

    // One limiter serves both polling loops; it is cleared on entry to each.
    assign wait_clr  = (st == XS_CMD) || (st == XS_DRESP);
    assign wait_step = xb_done && ((st == XS_TOKEN) || (st == XS_BUSY));
    assign wait_lim  = (st == XS_BUSY) ? busy_limit : token_limit;

    sd_xfer_wait #(.W(TO_W)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wait_clr),
        .step  (wait_step),
        .limit (wait_lim),
        .last  (wait_last)
    );

    // Drive the request lines, the outgoing byte and the buffer port from state.
    always_comb begin
        cmd_req   = (st == XS_CMD);
        xb_req    = (st inside {XS_TOKEN, XS_RDATA, XS_RCRC, XS_WTOK,
                                XS_WDATA, XS_WCRC, XS_DRESP, XS_BUSY});
        unique case (st)
            XS_WTOK:  xb_tx = TOKEN_START;
            XS_WDATA: xb_tx = buf_rdata;
            default:  xb_tx = FILL_BYTE;
        endcase
        buf_addr  = idx;
        buf_we    = (st == XS_RDATA) && xb_done;
        buf_wdata = xb_rx;
        done      = (st == XS_FIN);
        err       = (status_q != ST_OK);
        status    = status_q;
        cmd_idx   = cmd_idx_q;
        cmd_arg   = cmd_arg_q;
    end

    // Transfer sequencer: one state per phase, advancing on handshake pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= XS_IDLE;
            status_q  <= ST_OK;
            idx       <= '0;
            wr_q      <= 1'b0;
            cmd_idx_q <= '0;
            cmd_arg_q <= '0;
        end else begin
            unique case (st)
                XS_IDLE: if (start) begin
                    wr_q      <= wr;
                    cmd_idx_q <= wr ? CMD_WR_BLOCK : CMD_RD_BLOCK;
                    cmd_arg_q <= arg_w;
                    idx       <= '0;
                    if (!aligned_w) begin
                        status_q <= ST_ALIGN;
                        st       <= XS_FIN;
                    end else begin
                        status_q <= ST_OK;
                        st       <= XS_CMD;
                    end
                end
                XS_CMD: if (cmd_ack) begin
                    if (cmd_r1 != 8'h00) begin
                        status_q <= ST_R1;
                        st       <= XS_FIN;
                    end else begin
                        st <= wr_q ? XS_WTOK : XS_TOKEN;
                    end
                end
                XS_TOKEN: if (xb_done) begin
                    if (xb_rx == TOKEN_START) begin
                        st <= XS_RDATA;
                    end else if (wait_last) begin
                        status_q <= ST_TOKTO;
                        st       <= XS_FIN;
                    end
                end
                XS_RDATA, XS_WDATA: if (xb_done) begin
                    if (idx == LAST_IDX) begin
                        idx <= '0;
                        st  <= (st == XS_RDATA) ? XS_RCRC : XS_WCRC;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                XS_RCRC, XS_WCRC: if (xb_done) begin
                    if (idx == CRC_LAST) begin
                        idx <= '0;
                        st  <= (st == XS_RCRC) ? XS_FIN : XS_DRESP;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                XS_WTOK: if (xb_done) st <= XS_WDATA;
                XS_DRESP: if (xb_done) begin
                    unique case (xb_rx[3:1])
                        DR_ACCEPT: status_q <= ST_OK;
                        DR_CRC:    status_q <= ST_DCRC;
                        DR_WRITE:  status_q <= ST_DWERR;
                        default:   status_q <= ST_DBAD;
                    endcase
                    st <= XS_BUSY;
                end
                XS_BUSY: if (xb_done) begin
                    if (xb_rx == FILL_BYTE) begin
                        st <= XS_FIN;
                    end else if (wait_last) begin
                        status_q <= ST_BUSYTO;
                        st       <= XS_FIN;
                    end
                end
                XS_FIN:  st <= XS_IDLE;
                default: st <= XS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sd_block_xfer_chk.sv
`timescale 1ns/1ps
// Protocol checker for the single-block transfer engine, bound to every
// instance. It watches the handshakes and completion rules at the ports.
module sd_block_xfer_chk #(
    parameter int SHIFT  = 9,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              idle,
    input logic              start,
    input logic [ADDR_W-1:0] addr,
    input logic              cmd_req,
    input logic              cmd_ack,
    input logic [7:0]        cmd_r1,
    input logic [5:0]        cmd_idx,
    input logic              xb_req,
    input logic              xb_done,
    input logic [7:0]        xb_tx,
    input logic              buf_we,
    input logic              done,
    input logic [2:0]        status
);
    // R12
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_req && xb_req));

    // R12
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xb_req && !xb_done) |=> (xb_req && $stable(xb_tx)));

    // R2
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_idx)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    align_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && (addr[SHIFT-1:0] != '0)) |=> (done && status == 3'd7));

    // R3
    r1_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && cmd_ack && cmd_r1 != 8'h00) |=> (done && status == 3'd1));

    // R4
    store_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (xb_req && xb_done));
endmodule

bind sd_block_xfer sd_block_xfer_chk #(.SHIFT($clog2(BLK_BYTES)), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .idle    (st == sd_xfer_pkg::XS_IDLE),
    .start   (start),
    .addr    (addr),
    .cmd_req (cmd_req),
    .cmd_ack (cmd_ack),
    .cmd_r1  (cmd_r1),
    .cmd_idx (cmd_idx),
    .xb_req  (xb_req),
    .xb_done (xb_done),
    .xb_tx   (xb_tx),
    .buf_we  (buf_we),
    .done    (done),
    .status  (status)
);

// File: tb/sd_block_xfer_test.sv
`timescale 1ns/1ps
// Bench: a behavioural card model (queues of bytes to return, queues of bytes
// expected) checks every exchanged byte as it happens, and each transfer's
// result is compared with values worked out from the requirements.
module sd_block_xfer_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, start, wr, hc;
    logic [31:0] addr;
    logic [15:0] token_limit, busy_limit;
    logic        cmd_req, cmd_ack;
    logic [5:0]  cmd_idx;
    logic [31:0] cmd_arg;
    logic [7:0]  cmd_r1;
    logic        xb_req, xb_done;
    logic [7:0]  xb_tx, xb_rx;
    logic [8:0]  buf_addr;
    logic        buf_we;
    logic [7:0]  buf_wdata, buf_rdata;
    logic        done, err;
    logic [2:0]  status;

    logic [7:0] wmem [512];
    logic [7:0] got  [512];
    assign buf_rdata = wmem[buf_addr];

    sd_block_xfer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .hc(hc), .addr(addr),
        .token_limit(token_limit), .busy_limit(busy_limit),
        .cmd_req(cmd_req), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
        .cmd_ack(cmd_ack), .cmd_r1(cmd_r1),
        .xb_req(xb_req), .xb_tx(xb_tx), .xb_done(xb_done), .xb_rx(xb_rx),
        .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata), .done(done), .err(err), .status(status)
    );

    int nchk = 0, nerr = 0;
    int cycles = 0;

    logic [7:0] rxq [$];
    logic [7:0] exq [$];
    int nbytes = 0, ncmd = 0, nstore = 0, txmis = 0;
    logic [5:0]  seen_idx;
    logic [31:0] seen_arg;
    logic [7:0]  r1_val;
    logic        b_act = 1'b0, c_act = 1'b0;
    int          b_cnt = 0, c_cnt = 0;

    task automatic check(input string rq, input bit ok, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Card-side model of the SPI byte port and the command engine (negedge).
    always @(negedge clk) begin
        cycles++;
        if (xb_done) xb_done = 1'b0;
        else if (b_act) begin
            if (b_cnt == 0) begin
                xb_rx   = (rxq.size() != 0) ? rxq.pop_front() : 8'hFF;
                xb_done = 1'b1;
                b_act   = 1'b0;
            end else b_cnt--;
        end else if (xb_req) begin
            logic [7:0] e;
            e = (exq.size() != 0) ? exq.pop_front() : 8'hFF;
            if (xb_tx !== e) txmis++;
            nbytes++;
            b_act = 1'b1;
            b_cnt = 1;
        end
        if (cmd_ack) cmd_ack = 1'b0;
        else if (c_act) begin
            if (c_cnt == 0) begin
                cmd_r1  = r1_val;
                cmd_ack = 1'b1;
                c_act   = 1'b0;
            end else c_cnt--;
        end else if (cmd_req) begin
            seen_idx = cmd_idx;
            seen_arg = cmd_arg;
            ncmd++;
            c_act = 1'b1;
            c_cnt = 2;
        end
    end

    // Record buffer stores as the buffer would.
    always @(posedge clk) begin
        if (buf_we) begin
            got[buf_addr] <= buf_wdata;
            nstore <= nstore + 1;
        end
    end

    // Global watchdog: counts as a failure and still prints the summary.
    always @(negedge clk) begin
        if (cycles > 190000) begin
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    int b0, c0, s0, m0;
    logic [2:0] res_st;
    logic       res_err;

    task automatic run_xfer(input bit w, input bit h, input logic [31:0] a);
        int guard;
        b0 = nbytes; c0 = ncmd; s0 = nstore; m0 = txmis;
        @(negedge clk);
        wr = w; hc = h; addr = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check("R11 transfer completes", done === 1'b1, guard, 0);
        res_st  = status;
        res_err = err;
        @(negedge clk);
        check("R11 done is one cycle", done === 1'b0, done, 0);
        repeat (3) @(negedge clk);
        check("R11 status held", status === res_st, status, res_st);
        check("R11 err matches status", err === (status != 3'd0), err, (status != 3'd0));
        rxq.delete();
        exq.delete();
    endtask

    task automatic load_read(input int pre, input int seed);
        for (int i = 0; i < pre; i++) rxq.push_back(8'hFF);
        rxq.push_back(8'hFE);
        for (int i = 0; i < 512; i++) rxq.push_back(8'((i * 13 + seed) & 255));
        rxq.push_back(8'h5A);
        rxq.push_back(8'hC3);
    endtask

    task automatic check_read_data(input string rq, input int seed);
        int bad = 0, first = -1;
        for (int i = 0; i < 512; i++)
            if (got[i] !== 8'((i * 13 + seed) & 255)) begin
                bad++;
                if (first < 0) first = i;
            end
        check(rq, bad == 0, bad, 0);
    endtask

    task automatic load_write(input int seed, input logic [7:0] resp, input int nbusy);
        for (int i = 0; i < 512; i++) wmem[i] = 8'((i * 7 + seed) & 255);
        exq.push_back(8'hFE);
        for (int i = 0; i < 512; i++) exq.push_back(wmem[i]);
        exq.push_back(8'hFF);
        exq.push_back(8'hFF);
        for (int i = 0; i < 515; i++) rxq.push_back(8'hFF);
        rxq.push_back(resp);
        for (int i = 0; i < nbusy; i++) rxq.push_back(8'h00);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; wr = 1'b0; hc = 1'b0; addr = '0;
        token_limit = 16'd64; busy_limit = 16'd64;
        xb_done = 1'b0; xb_rx = 8'h00; cmd_ack = 1'b0; cmd_r1 = 8'h00; r1_val = 8'h00;
        for (int i = 0; i < 512; i++) wmem[i] = 8'h00;
        repeat (3) @(negedge clk);
        check("R11 reset done", done === 1'b0, done, 0);
        check("R11 reset err/status", err === 1'b0 && status === 3'd0, status, 0);
        check("R12 reset requests idle", cmd_req === 1'b0 && xb_req === 1'b0, {cmd_req, xb_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: misaligned address
        run_xfer(1'b0, 1'b0, 32'h0000_0201);
        check("R1 misaligned status", res_st === 3'd7, res_st, 7);
        check("R1 no command or byte", (ncmd - c0) == 0 && (nbytes - b0) == 0, ncmd - c0 + nbytes - b0, 0);

        // R2/R4/R5: byte-addressed read with three idle bytes before the token
        load_read(3, 5);
        run_xfer(1'b0, 1'b0, 32'h0000_0400);
        check("R2 read index", seen_idx === 6'd17, seen_idx, 17);
        check("R2 byte address argument", seen_arg === 32'h400, seen_arg, 32'h400);
        check_read_data("R4 stored payload", 5);
        check("R4 store count", (nstore - s0) == 512, nstore - s0, 512);
        check("R5 exchange count", (nbytes - b0) == 518, nbytes - b0, 518);
        check("R5 read status", res_st === 3'd0 && res_err === 1'b0, res_st, 0);
        check("R12 read sends only idle bytes", (txmis - m0) == 0, txmis - m0, 0);

        // R2/R4: block-addressed read, token first, different pattern
        load_read(0, 200);
        run_xfer(1'b0, 1'b1, 32'h0000_0600);
        check("R2 block number argument", seen_arg === 32'd3, seen_arg, 3);
        check_read_data("R4 stored payload second pattern", 200);
        check("R5 exchange count no preamble", (nbytes - b0) == 515, nbytes - b0, 515);

        // R3: rejected command
        r1_val = 8'h04;
        run_xfer(1'b0, 1'b0, 32'h0000_0200);
        check("R3 r1 status", res_st === 3'd1 && res_err === 1'b1, res_st, 1);
        check("R3 no byte exchange", (nbytes - b0) == 0, nbytes - b0, 0);
        r1_val = 8'h00;

        // R6: token never arrives
        token_limit = 16'd5;
        run_xfer(1'b0, 1'b0, 32'h0000_0000);
        check("R6 token timeout status", res_st === 3'd2, res_st, 2);
        check("R6 bytes examined", (nbytes - b0) == 5, nbytes - b0, 5);
        check("R6 nothing stored", (nstore - s0) == 0, nstore - s0, 0);
        token_limit = 16'd64;

        // R7/R8/R9: accepted write with two busy bytes
        load_write(3, 8'hE5, 2);
        run_xfer(1'b1, 1'b0, 32'h0000_0800);
        check("R2 write index", seen_idx === 6'd24, seen_idx, 24);
        check("R2 write argument", seen_arg === 32'h800, seen_arg, 32'h800);
        check("R7 write byte stream", (txmis - m0) == 0, txmis - m0, 0);
        check("R9 exchange count", (nbytes - b0) == 519, nbytes - b0, 519);
        check("R8 accepted status", res_st === 3'd0, res_st, 0);

        // R8/R9: response code 101, busy wait still runs
        load_write(9, 8'h0B, 1);
        run_xfer(1'b1, 1'b1, 32'h0000_1000);
        check("R8 crc reject status", res_st === 3'd3 && res_err === 1'b1, res_st, 3);
        check("R9 busy after reject", (nbytes - b0) == 518, nbytes - b0, 518);
        check("R2 write block argument", seen_arg === 32'd8, seen_arg, 8);

        // R8: response code 110
        load_write(1, 8'h0D, 0);
        run_xfer(1'b1, 1'b0, 32'h0000_0000);
        check("R8 write error status", res_st === 3'd4, res_st, 4);
        check("R7 write stream third pattern", (txmis - m0) == 0, txmis - m0, 0);

        // R8: unknown response code 011
        load_write(2, 8'h07, 0);
        run_xfer(1'b1, 1'b0, 32'h0000_0200);
        check("R8 unknown code status", res_st === 3'd5, res_st, 5);

        // R10: card stays busy
        busy_limit = 16'd4;
        load_write(4, 8'h05, 10);
        run_xfer(1'b1, 1'b0, 32'h0000_0400);
        check("R10 busy timeout status", res_st === 3'd6, res_st, 6);
        check("R10 busy bytes examined", (nbytes - b0) == 520, nbytes - b0, 520);
        busy_limit = 16'd64;

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule